// File: doc/BRIEF.md
# Dual-Vector Bus Interrupt Controller

This block lets user logic interrupt a bus master through two independent channels. Each channel has its own request input, its own priority level (one of four request lines, standing for levels 4 to 7) and its own 6-bit vector. When user logic raises a channel's request, the channel drives the request line of its level. It then waits for the matching grant, acknowledges it and tells user logic that it has been selected. Once the bus is no longer busy, it takes the bus and places its vector on the data lines.

Grants are daisy-chained. A channel that is idle and not requesting passes a grant through to the grant output of its level. A channel that is requesting or active holds that output low. When both channels sit on the same level, channel B is fed internally from channel A's grant output, so channel A comes first in the chain. The transfer ends when the master's slave-sync response arrives, or after a configurable number of cycles.

Top module: `irq_pair_ctrl`

## Requirements
- R1: A synchronous active-low reset returns both channels to idle. All bus outputs, request lines, select status and strobes are then low, and the grant outputs copy the grant inputs.
- R2: While a channel is idle and its request input is high, the request line given by its 2-bit level code is driven high (code 0 is level 4, code 3 is level 7, bit k of `bus_req` is code k).
- R3: A channel whose request is high when its grant is high at a clock edge shows `sel_ack` and its `dev_sel` bit high from the next cycle, and its request line drops.
- R4: While a channel transfers, `vec_data` carries the vector in bits 7..2, and bits 15..8 and 1..0 are zero. At all other times `vec_data` is zero.
- R5: A selected channel holds off while `bus_busy_in` is high. After the first edge at which it sees the bus free, it drives `bus_busy_out`, `intr_out` and its `vec_strobe` bit high.
- R6: When `ssyn_in` is high during a transfer, the next cycle releases busy, interrupt, strobe, `sel_ack` and the channel's `dev_sel` bit.
- R7: An idle channel whose request is low copies its grant input to its grant output and never captures that grant.
- R8: A channel that is requesting, selected or transferring holds its level's grant output low.
- R9: When both level codes are equal, channel B's grant is channel A's grant output. With both requesting, A is selected and B is not.
- R10: Without `ssyn_in`, a transfer lasts exactly `XFER_LIMIT` cycles and is then released.
- R11: At most one channel transfers at a time. When both are selected and the bus becomes free, channel A goes first and B follows one cycle after A releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 2 | User request per channel (bit 0 = A, bit 1 = B) |
| lvl_a | input | 2 | Level code of channel A (0..3 = level 4..7) |
| lvl_b | input | 2 | Level code of channel B |
| vec_a | input | 6 | Vector of channel A |
| vec_b | input | 6 | Vector of channel B |
| bus_gnt_in | input | 4 | Grant inputs, one per level, high true |
| bus_busy_in | input | 1 | Bus held by another master |
| ssyn_in | input | 1 | Slave-sync response from the master |
| bus_req | output | 4 | Request lines, one per level, high true |
| bus_gnt_out | output | 4 | Grant outputs to the next device on the chain |
| sel_ack | output | 1 | Grant acknowledge to the master |
| bus_busy_out | output | 1 | Bus taken by this block |
| intr_out | output | 1 | Interrupt line, high during a vector transfer |
| vec_data | output | 16 | Data lines carrying the vector |
| dev_sel | output | 2 | Select status per channel; user logic may drop its request |
| vec_strobe | output | 2 | High per channel while its vector is on the data lines |

## Verification
The bench targets the chained grant on a shared level. A design that fed channel B straight from the bus grant would select both channels at once or leak the grant downstream. It also checks a grant that arrives while nothing is requesting: a design that latched it would raise `sel_ack` spuriously instead of passing the grant on. Further cases are two channels selected together and the hand-off after channel A releases, which would break if both drove the data lines. Last come the exact length of an unanswered transfer and a reset taken in the middle of a transfer; a wrong counter or a late reset would leave busy or the strobe held.

// File: rtl/irq_pair_pkg.sv
// Package: types and sizes shared by the dual-vector interrupt controller.
// Assumes a four-level request/grant chain and a 16-bit data bus.
package irq_pair_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int VEC_W   = 6;
    localparam int VEC_LSB = 2;
    localparam int DATA_W  = 16;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_SEL  = 2'd1,
        CH_XFER = 2'd2
    } ch_state_t;
endpackage

// File: rtl/irq_channel.sv
// One interrupt channel: request, grant capture, wait for a free bus,
// then vector transfer ended by slave sync or a cycle limit.
// Assumes gnt_in is already routed to this channel's level.
module irq_channel
    import irq_pair_pkg::*;
#(
    parameter int XFER_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic gnt_in,
    input  logic bus_free,
    input  logic ssyn,
    output logic req_line,
    output logic gnt_pass,
    output logic selected,
    output logic waiting,
    output logic xfer
);
    localparam int CNT_W = $clog2(XFER_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_LIMIT - 1);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state decode for the channel handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (req && gnt_in) state_d = CH_SEL;
            CH_SEL:  if (bus_free)      state_d = CH_XFER;
            CH_XFER: if (ssyn || cnt_q == CNT_LAST) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Transfer cycle counter, cleared outside the transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != CH_XFER) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    assign req_line = req && (state_q == CH_IDLE);
    assign gnt_pass = gnt_in && !req && (state_q == CH_IDLE);
    assign waiting  = (state_q == CH_SEL);
    assign xfer     = (state_q == CH_XFER);
    assign selected = waiting || xfer;
endmodule

// File: rtl/irq_grant_route.sv
// Grant routing: picks each channel's grant input, chains B behind A when
// both share a level, and forms the request lines and grant outputs.
// Assumes at most two channels map onto the level lines.
module irq_grant_route
    import irq_pair_pkg::*;
(
    input  logic [LVL_W-1:0]   lvl_a,
    input  logic [LVL_W-1:0]   lvl_b,
    input  logic [NUM_LVL-1:0] gnt_in,
    input  logic               req_line_a,
    input  logic               req_line_b,
    input  logic               pass_a,
    input  logic               pass_b,
    output logic               gin_a,
    output logic               gin_b,
    output logic [NUM_LVL-1:0] req_out,
    output logic [NUM_LVL-1:0] gnt_out
);
    logic same_lvl;

    assign same_lvl = (lvl_a == lvl_b);
    assign gin_a    = gnt_in[lvl_a];
    assign gin_b    = same_lvl ? pass_a : gnt_in[lvl_b];

    // Per-level request OR and grant-out selection.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign req_out[l] = (req_line_a && lvl_a == LVL_W'(l)) ||
                            (req_line_b && lvl_b == LVL_W'(l));
        assign gnt_out[l] = (lvl_b == LVL_W'(l)) ? pass_b :
                            (lvl_a == LVL_W'(l)) ? pass_a : gnt_in[l];
    end
endmodule

// File: rtl/irq_vec_drive.sv
// Bus-side drive: busy, interrupt and data lines from the channel that
// transfers. Assumes at most one channel transfers at a time; A wins.
module irq_vec_drive
    import irq_pair_pkg::*;
(
    input  logic              xfer_a,
    input  logic              xfer_b,
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_b,
    output logic              busy,
    output logic              intr,
    output logic [DATA_W-1:0] data
);
    // Data line mux with vector placed above the two zero bits.
    always_comb begin
        data = '0;
        if (xfer_a)      data = DATA_W'(vec_a) << VEC_LSB;
        else if (xfer_b) data = DATA_W'(vec_b) << VEC_LSB;
    end

    assign busy = xfer_a || xfer_b;
    assign intr = xfer_a || xfer_b;
endmodule

// File: rtl/irq_pair_ctrl.sv
// Top: two interrupt channels sharing one bus interface. Channel A has
// precedence when both want the bus in the same cycle.
// Assumes level and vector inputs are static while a channel is active.
module irq_pair_ctrl
    import irq_pair_pkg::*;
#(
    parameter int XFER_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         dev_req,
    input  logic [LVL_W-1:0]   lvl_a,
    input  logic [LVL_W-1:0]   lvl_b,
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    input  logic [NUM_LVL-1:0] bus_gnt_in,
    input  logic               bus_busy_in,
    input  logic               ssyn_in,
    output logic [NUM_LVL-1:0] bus_req,
    output logic [NUM_LVL-1:0] bus_gnt_out,
    output logic               sel_ack,
    output logic               bus_busy_out,
    output logic               intr_out,
    output logic [DATA_W-1:0]  vec_data,
    output logic [1:0]         dev_sel,
    output logic [1:0]         vec_strobe
);
    logic gin_a, gin_b, pass_a, pass_b, rl_a, rl_b;
    logic sel_a, sel_b, wait_a, wait_b, xfer_a, xfer_b;
    logic free_a, free_b;

    // A waits only for outside traffic and B; B also yields to a waiting A.
    assign free_a = !bus_busy_in && !xfer_b;
    assign free_b = !bus_busy_in && !xfer_a && !wait_a;

    irq_channel #(.XFER_LIMIT(XFER_LIMIT)) ch_a_i (
        .clk(clk), .rst_n(rst_n), .req(dev_req[0]), .gnt_in(gin_a),
        .bus_free(free_a), .ssyn(ssyn_in), .req_line(rl_a), .gnt_pass(pass_a),
        .selected(sel_a), .waiting(wait_a), .xfer(xfer_a)
    );

    irq_channel #(.XFER_LIMIT(XFER_LIMIT)) ch_b_i (
        .clk(clk), .rst_n(rst_n), .req(dev_req[1]), .gnt_in(gin_b),
        .bus_free(free_b), .ssyn(ssyn_in), .req_line(rl_b), .gnt_pass(pass_b),
        .selected(sel_b), .waiting(wait_b), .xfer(xfer_b)
    );

    irq_grant_route route_i (
        .lvl_a(lvl_a), .lvl_b(lvl_b), .gnt_in(bus_gnt_in),
        .req_line_a(rl_a), .req_line_b(rl_b), .pass_a(pass_a), .pass_b(pass_b),
        .gin_a(gin_a), .gin_b(gin_b), .req_out(bus_req), .gnt_out(bus_gnt_out)
    );

    irq_vec_drive drive_i (
        .xfer_a(xfer_a), .xfer_b(xfer_b), .vec_a(vec_a), .vec_b(vec_b),
        .busy(bus_busy_out), .intr(intr_out), .data(vec_data)
    );

    assign sel_ack    = sel_a || sel_b;
    assign dev_sel    = {sel_b, sel_a};
    assign vec_strobe = {xfer_b, xfer_a};
endmodule

// File: rtl/irq_pair_chk.sv
// Checker for irq_pair_ctrl, attached by bind. Observes ports only.
module irq_pair_chk
    import irq_pair_pkg::*;
#(
    parameter int XFER_LIMIT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         dev_req,
    input logic [NUM_LVL-1:0] bus_gnt_in,
    input logic               bus_busy_in,
    input logic               ssyn_in,
    input logic               sel_ack,
    input logic               bus_busy_out,
    input logic               intr_out,
    input logic [DATA_W-1:0]  vec_data,
    input logic [1:0]         dev_sel,
    input logic [1:0]         vec_strobe
);
    logic [15:0] run_q;

    // Length of the current strobe run, for the transfer bound.
    always_ff @(posedge clk) begin
        if (!rst_n || vec_strobe == 2'b00) run_q <= '0;
        else if (run_q != 16'hFFFF)        run_q <= run_q + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sel_ack && !bus_busy_out && dev_sel == 2'b00)); // R1
    AST_SEL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_sel[0]) |-> ($past(dev_req[0]) && $past(|bus_gnt_in))); // R3
    AST_VEC_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_data[1:0] == 2'b00 && vec_data[15:8] == 8'h00)); // R4
    AST_XFER_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_strobe[0]) |-> !$past(bus_busy_in)); // R5
    AST_STROBE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (|vec_strobe) |-> (sel_ack && bus_busy_out && intr_out)); // R5
    AST_SSYN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_strobe[0] && ssyn_in) |=> !vec_strobe[0]); // R6
    AST_XFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 16'(XFER_LIMIT)); // R10
    AST_ONE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec_strobe) <= 1); // R11
endmodule

bind irq_pair_ctrl irq_pair_chk #(.XFER_LIMIT(XFER_LIMIT)) chk_i (.*);

// File: tb/irq_pair_ctrl_tb.sv
// Directed bench for irq_pair_ctrl: one task per scenario.
module irq_pair_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int LIM   = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  dev_req;
    logic [1:0]  lvl_a, lvl_b;
    logic [5:0]  vec_a, vec_b;
    logic [3:0]  bus_gnt_in;
    logic        bus_busy_in, ssyn_in;
    logic [3:0]  bus_req, bus_gnt_out;
    logic        sel_ack, bus_busy_out, intr_out;
    logic [15:0] vec_data;
    logic [1:0]  dev_sel, vec_strobe;

    int n_chk = 0;
    int n_fail = 0;

    irq_pair_ctrl #(.XFER_LIMIT(LIM)) dut_i (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0; dev_req = 2'b00; bus_gnt_in = 4'h0;
        bus_busy_in = 1'b1; ssyn_in = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        bus_gnt_in = 4'b1010; #1;
        chk("R1 sel_ack", {31'd0, sel_ack}, 0);
        chk("R1 busy/intr", {30'd0, bus_busy_out, intr_out}, 0);
        chk("R1 bus_req", {28'd0, bus_req}, 0);
        chk("R1 gnt pass", {28'd0, bus_gnt_out}, 32'b1010);
        bus_gnt_in = 4'h0;
    endtask

    task automatic t_handshake();
        lvl_a = 2'd1; vec_a = 6'h2A; lvl_b = 2'd3;
        step(); dev_req = 2'b01; #1;
        chk("R2 req A lvl5", {28'd0, bus_req}, 32'b0010);
        dev_req = 2'b11; #1;
        chk("R2 req A+B", {28'd0, bus_req}, 32'b1010);
        dev_req = 2'b01;
        bus_gnt_in = 4'b0010; #1;
        chk("R8 grant blocked", {28'd0, bus_gnt_out}, 32'b0000);
        step();
        chk("R3 sel_ack", {31'd0, sel_ack}, 1);
        chk("R3 dev_sel", {30'd0, dev_sel}, 32'b01);
        chk("R3 req drops", {28'd0, bus_req}, 0);
        dev_req = 2'b00; #1;
        chk("R8 selected blocks", {28'd0, bus_gnt_out}, 0);
        bus_gnt_in = 4'h0;
        step();
        chk("R5 hold while busy", {30'd0, vec_strobe}, 0);
        chk("R5 still selected", {30'd0, dev_sel}, 32'b01);
        bus_busy_in = 1'b0;
        step();
        chk("R5 strobe", {30'd0, vec_strobe}, 32'b01);
        chk("R5 busy+intr", {30'd0, bus_busy_out, intr_out}, 32'b11);
        chk("R4 vector A", {16'd0, vec_data}, 32'h00A8);
        ssyn_in = 1'b1;
        step(); ssyn_in = 1'b0;
        chk("R6 released", {26'd0, sel_ack, bus_busy_out, intr_out, vec_strobe, dev_sel[0]}, 0);
        chk("R4 data idle", {16'd0, vec_data}, 0);
    endtask

    task automatic t_passthrough();
        step(); dev_req = 2'b00; bus_gnt_in = 4'b1111; #1;
        chk("R7 pass all", {28'd0, bus_gnt_out}, 32'b1111);
        repeat (2) step();
        chk("R7 no capture", {29'd0, sel_ack, dev_sel}, 0);
        bus_gnt_in = 4'h0;
    endtask

    task automatic t_chain();
        do_reset(); bus_busy_in = 1'b1;
        lvl_a = 2'd2; lvl_b = 2'd2; vec_a = 6'h11; vec_b = 6'h3F;
        step(); dev_req = 2'b10; bus_gnt_in = 4'b0100; #1;
        chk("R9 B blocks chain", {28'd0, bus_gnt_out}, 0);
        step(); dev_req = 2'b00; bus_gnt_in = 4'h0;
        chk("R9 B via A", {30'd0, dev_sel}, 32'b10);
        bus_busy_in = 1'b0;
        step();
        chk("R4 vector B", {16'd0, vec_data}, 32'h00FC);
        ssyn_in = 1'b1; step(); ssyn_in = 1'b0;
        dev_req = 2'b11; bus_busy_in = 1'b1; bus_gnt_in = 4'b0100;
        step();
        chk("R9 A first", {30'd0, dev_sel}, 32'b01);
        dev_req = 2'b10; bus_busy_in = 1'b0;
        step(); ssyn_in = 1'b1;
        step(); ssyn_in = 1'b0;
        chk("R9 gap", {30'd0, dev_sel}, 0);
        step();
        chk("R9 B follows", {30'd0, dev_sel}, 32'b10);
        dev_req = 2'b00; bus_gnt_in = 4'h0;
    endtask

    task automatic t_both_selected();
        do_reset(); bus_busy_in = 1'b1;
        lvl_a = 2'd0; lvl_b = 2'd3; vec_a = 6'h05; vec_b = 6'h09;
        step(); dev_req = 2'b11; bus_gnt_in = 4'b1001;
        step(); dev_req = 2'b00; bus_gnt_in = 4'h0;
        chk("R11 both selected", {30'd0, dev_sel}, 32'b11);
        bus_busy_in = 1'b0;
        step();
        chk("R11 A wins", {30'd0, vec_strobe}, 32'b01);
        ssyn_in = 1'b1; step(); ssyn_in = 1'b0;
        chk("R11 gap", {29'd0, sel_ack, vec_strobe}, 32'b100);
        step();
        chk("R11 B next", {30'd0, vec_strobe}, 32'b10);
        chk("R4 vector B2", {16'd0, vec_data}, 32'h0024);
        ssyn_in = 1'b1; step(); ssyn_in = 1'b0;
    endtask

    task automatic t_timeout();
        int run = 0;
        do_reset(); bus_busy_in = 1'b0;
        lvl_a = 2'd3; vec_a = 6'h01;
        step(); dev_req = 2'b01; bus_gnt_in = 4'b1000;
        step(); dev_req = 2'b00; bus_gnt_in = 4'h0;
        step();
        chk("R4 vector 1", {16'd0, vec_data}, 32'h0004);
        for (int i = 0; i < 20 && vec_strobe[0]; i++) begin
            run++;
            step();
        end
        chk("R10 length", run, LIM);
        chk("R10 released", {30'd0, bus_busy_out, sel_ack}, 0);
    endtask

    task automatic t_reset_mid();
        do_reset(); bus_busy_in = 1'b0;
        lvl_a = 2'd1;
        step(); dev_req = 2'b01; bus_gnt_in = 4'b0010;
        step(); dev_req = 2'b00; bus_gnt_in = 4'h0;
        step();
        chk("R1 in xfer", {30'd0, vec_strobe}, 32'b01);
        rst_n = 1'b0;
        step(); rst_n = 1'b1;
        chk("R1 mid reset", {27'd0, sel_ack, bus_busy_out, intr_out, vec_strobe}, 0);
    endtask

    initial begin
        rst_n = 1'b0; dev_req = 2'b00; lvl_a = 2'd0; lvl_b = 2'd1;
        vec_a = '0; vec_b = '0; bus_gnt_in = 4'h0;
        bus_busy_in = 1'b1; ssyn_in = 1'b0;
        t_reset_state();
        t_handshake();
        t_passthrough();
        t_chain();
        t_both_selected();
        t_timeout();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule